// File: doc/BRIEF.md
# Cartridge Slot Power Sequencer

This block owns the power state of a cartridge slot and drives the power-enable and reset lines of two physical connectors. Software reads and writes two 16-bit registers over a small register bus. The first is a control word. It reports whether a card is present and holds the 2-bit power state of the working slot. It also holds a bit that exchanges the two physical connectors. The second register holds the power-off delay.

The power state moves only when software writes it, with one exception. A power-off request is a timed state. The block loads its timeout from the delay register when the request is entered. When the timeout expires, the block drops the slot to off without further help. The delay is counted in units of 1024 clock cycles, so the largest value spans about one second at a 67 MHz clock. The second logical slot is a fixed placeholder: it always reads as ejected and powered off. The swap bit decides which physical connector serves the working slot. The other connector is held unpowered and in reset.

Top module: `cart_slot_sequencer`

## Requirements
- R1: After reset the power state is 0 (off), the swap bit is 0, the delay register is 0, both power enables are low and both reset outputs are high.
- R2: Reading the control word (address 0) gives bit 0 = ejected flag of the connector serving the working slot (1 = ejected), bits 3:2 = power state, bit 4 = 1, bit 15 = swap, and 0 in every other bit; writes to bits 0, 4 and the zero bits have no effect.
- R3: A write to address 0 sets the power state from bits 3:2 (0 = off, 1 = on with reset, 2 = on, 3 = off requested) when the current state is not 3.
- R4: State 1 never changes by itself; it remains until software writes a new state.
- R5: While the state is 3, the power-state bits of a control write are ignored, but bit 15 of the same write still updates the swap bit.
- R6: With delay register value D when state 3 is entered, the state reads 3 for exactly D*1024+1 cycles and then reads 0; D = 0 gives one cycle in state 3.
- R7: The timeout is captured on entry to state 3; writing the delay register while in state 3 does not change the current timeout.
- R8: The connector serving the working slot has power enable high in states 1, 2 and 3 and reset high in every state except 2; the other connector always has power enable low and reset high.
- R9: Swap = 0 maps the working slot to connector 0, and swap = 1 maps it to connector 1; the card-detect bit and the power and reset outputs follow the mapping.
- R10: The delay register (address 1) reads back all 16 bits last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 1 | Register select: 0 control word, 1 delay |
| regWrEn | input | 1 | Write strobe for the selected register |
| regWrData | input | 16 | Write data |
| regRdData | output | 16 | Read data of the selected register (combinational) |
| cardEjected | input | 2 | Per-connector card-detect, 1 = no card |
| slotPowerEn | output | 2 | Per-connector power enable |
| slotReset | output | 2 | Per-connector reset, 1 = held in reset |

## Verification
The main target is the exact length of the power-off request. The bench runs delays of 0, 1 and 2 units. A counter that is off by one unit or one cycle makes the state fall to 0 a cycle early or late, and the per-clock comparison catches that. A request made while a power-off is already in progress must not reload the timer or change the state. A design that accepted the write would jump straight to on, or would stretch the timeout when the delay register is rewritten mid-request. State 1 is held for a long idle stretch, so any design that advanced it by itself shows up. Swap is toggled while the slot is powered, including during a request. A wrong connector mapping would show power or a card-detect value on the wrong connector.

// File: rtl/cart_seq_pkg.sv
package cart_seq_pkg;
  typedef enum logic [1:0] {
    PWR_OFF     = 2'd0,
    PWR_ON_RST  = 2'd1,
    PWR_ON      = 2'd2,
    PWR_OFF_REQ = 2'd3
  } pwrState_e;

  typedef struct packed {
    logic loadTimer;
    logic runTimer;
  } seqStrobe_t;

  localparam int STATE_LSB  = 2;
  localparam int SWAP_BIT   = 15;
  localparam int DETECT_BIT = 0;
  localparam int SLOT2_BIT  = 4;
endpackage

// File: rtl/cart_seq_ctrl.sv
module cart_seq_ctrl
  import cart_seq_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              timerDone,
  output pwrState_e         pwrState,
  output logic              swapSel,
  output seqStrobe_t        strobe
);
  pwrState_e reqState;

  assign reqState = pwrState_e'(wrData[STATE_LSB +: 2]);

  always_comb begin
    strobe.runTimer  = (pwrState == PWR_OFF_REQ);
    strobe.loadTimer = ctrlWrEn && (pwrState != PWR_OFF_REQ) && (reqState == PWR_OFF_REQ);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pwrState <= PWR_OFF;
      swapSel  <= 1'b0;
    end else begin
      if (ctrlWrEn) swapSel <= wrData[SWAP_BIT];
      if (pwrState == PWR_OFF_REQ) begin
        if (timerDone) pwrState <= PWR_OFF;
      end else if (ctrlWrEn) begin
        pwrState <= reqState;
      end
    end
  end
endmodule

// File: rtl/cart_seq_dp.sv
module cart_seq_dp
  import cart_seq_pkg::*;
#(
  parameter int DELAY_W   = 16,
  parameter int UNIT_LOG2 = 10
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               delayWrEn,
  input  logic [DELAY_W-1:0] wrData,
  input  seqStrobe_t         strobe,
  output logic [DELAY_W-1:0] delayVal,
  output logic               timerDone
);
  localparam logic [UNIT_LOG2-1:0] PRE_MAX = {UNIT_LOG2{1'b1}};

  logic [UNIT_LOG2-1:0] preCnt;
  logic [DELAY_W-1:0]   unitCnt;

  assign timerDone = (unitCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      delayVal <= '0;
    end else if (delayWrEn) begin
      delayVal <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt  <= '0;
      unitCnt <= '0;
    end else if (strobe.loadTimer) begin
      preCnt  <= '0;
      unitCnt <= delayVal;
    end else if (strobe.runTimer && !timerDone) begin
      if (preCnt == PRE_MAX) begin
        preCnt  <= '0;
        unitCnt <= unitCnt - 1'b1;
      end else begin
        preCnt <= preCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cart_slot_sequencer.sv
module cart_slot_sequencer
  import cart_seq_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int UNIT_LOG2 = 10,
  parameter int NUM_PHYS  = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regAddr,
  input  logic                regWrEn,
  input  logic [DATA_W-1:0]   regWrData,
  output logic [DATA_W-1:0]   regRdData,
  input  logic [NUM_PHYS-1:0] cardEjected,
  output logic [NUM_PHYS-1:0] slotPowerEn,
  output logic [NUM_PHYS-1:0] slotReset
);
  pwrState_e         pwrState;
  logic              swapSel;
  logic              timerDone;
  seqStrobe_t        strobe;
  logic [DATA_W-1:0] delayVal;
  logic [DATA_W-1:0] ctrlWord;
  logic              activeEjected;

  cart_seq_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .ctrlWrEn (regWrEn && !regAddr),
    .wrData   (regWrData),
    .timerDone(timerDone),
    .pwrState (pwrState),
    .swapSel  (swapSel),
    .strobe   (strobe)
  );

  cart_seq_dp #(.DELAY_W(DATA_W), .UNIT_LOG2(UNIT_LOG2)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .delayWrEn(regWrEn && regAddr),
    .wrData   (regWrData),
    .strobe   (strobe),
    .delayVal (delayVal),
    .timerDone(timerDone)
  );

  assign activeEjected = swapSel ? cardEjected[1] : cardEjected[0];

  for (genvar g = 0; g < NUM_PHYS; g++) begin : g_phys
    logic isActive;
    assign isActive       = (g == 0) ? !swapSel : ((g == 1) ? swapSel : 1'b0);
    assign slotPowerEn[g] = isActive && (pwrState != PWR_OFF);
    assign slotReset[g]   = !(isActive && (pwrState == PWR_ON));
  end

  always_comb begin
    ctrlWord                   = '0;
    ctrlWord[DETECT_BIT]       = activeEjected;
    ctrlWord[STATE_LSB +: 2]   = pwrState;
    ctrlWord[SLOT2_BIT]        = 1'b1;
    ctrlWord[SWAP_BIT]         = swapSel;
  end

  assign regRdData = regAddr ? delayVal : ctrlWord;
endmodule

// File: rtl/cart_seq_checker.sv
module cart_seq_checker (
  input logic        clk,
  input logic        rstN,
  input logic        regAddr,
  input logic        regWrEn,
  input logic [15:0] regRdData,
  input logic [1:0]  slotPowerEn,
  input logic [1:0]  slotReset,
  input logic [1:0]  pwrState,
  input logic        timerDone
);
  a_r4_hold_on_reset: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState == 2'd1 && !(regWrEn && !regAddr)) |=> (pwrState == 2'd1));

  a_r5_no_write_in_request: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState == 2'd3) |=> (pwrState == 2'd3 || pwrState == 2'd0));

  a_r6_timeout_exit: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState == 2'd3 && timerDone) |=> (pwrState == 2'd0));

  a_r8_one_powered: assert property (@(posedge clk) disable iff (!rstN)
    $countones(slotPowerEn) <= 1);

  a_r8_reset_unless_on: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState != 2'd2) |-> (slotReset == 2'b11));

  a_r2_fixed_bits: assert property (@(posedge clk) disable iff (!rstN)
    (!regAddr) |-> (regRdData[14:4] == 11'h001 && regRdData[1] == 1'b0));
endmodule

bind cart_slot_sequencer cart_seq_checker u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .regAddr    (regAddr),
  .regWrEn    (regWrEn),
  .regRdData  (regRdData),
  .slotPowerEn(slotPowerEn),
  .slotReset  (slotReset),
  .pwrState   (pwrState),
  .timerDone  (timerDone)
);

// File: tb/test_cart_slot_sequencer.sv
module test_cart_slot_sequencer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regAddr = 1'b0;
  logic        regWrEn = 1'b0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic [1:0]  cardEjected = 2'b00;
  logic [1:0]  slotPowerEn;
  logic [1:0]  slotReset;

  int    vectors = 0;
  int    miscompares = 0;
  string curReq = "R1";
  bit    finished = 1'b0;

  int          mState = 0;
  bit          mSwap = 0;
  int          mDelay = 0;
  int          mCount = 0;

  always #4 clk = ~clk;

  cart_slot_sequencer i_cart_slot_sequencer (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .cardEjected(cardEjected),
    .slotPowerEn(slotPowerEn), .slotReset(slotReset)
  );

  function automatic logic [15:0] expRead();
    logic [15:0] w;
    if (regAddr) return 16'(mDelay);
    w = 16'h0010;
    w[0] = mSwap ? cardEjected[1] : cardEjected[0];
    w[3:2] = 2'(mState);
    w[15] = mSwap;
    return w;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mState = 0; mSwap = 0; mDelay = 0; mCount = 0;
    end else begin
      if (mState == 3) begin
        if (mCount == 0) mState = 0;
        else mCount--;
      end else if (regWrEn && !regAddr) begin
        mState = int'(regWrData[3:2]);
        if (mState == 3) mCount = mDelay * 1024;
      end
      if (regWrEn && !regAddr) mSwap = regWrData[15];
      if (regWrEn && regAddr) mDelay = int'(regWrData);
    end
    #2;
    begin
      logic [1:0] ePwr, eRst;
      for (int g = 0; g < 2; g++) begin
        bit act;
        act = (mSwap == g[0]);
        ePwr[g] = act && (mState != 0);
        eRst[g] = !(act && (mState == 2));
      end
      vectors++;
      if (regRdData !== expRead() || slotPowerEn !== ePwr || slotReset !== eRst) begin
        miscompares++;
        $display("FAIL %s t=%0t rd=%h/%h pwr=%b/%b rst=%b/%b (actual/expected)",
                 curReq, $time, regRdData, expRead(), slotPowerEn, ePwr, slotReset, eRst);
      end
    end
  end

  task automatic wr(input logic a, input logic [15:0] d);
    @(negedge clk);
    regAddr = a; regWrEn = 1'b1; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regAddr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    curReq = "R1";
    idle(3);
    rstN = 1'b1;
    idle(3);
    curReq = "R10";
    wr(1'b1, 16'hA5C3);
    @(negedge clk); regAddr = 1'b1; idle(2); regAddr = 1'b0;
    wr(1'b1, 16'h0000);
    curReq = "R2";
    wr(1'b0, 16'h7FF3 & ~16'h000C);
    cardEjected = 2'b01; idle(2);
    cardEjected = 2'b10; idle(2);
    curReq = "R3";
    wr(1'b0, 16'h0008); idle(3);
    wr(1'b0, 16'h0000); idle(2);
    curReq = "R4";
    wr(1'b0, 16'h0004); idle(40);
    wr(1'b0, 16'h0008); idle(2);
    curReq = "R9";
    cardEjected = 2'b01;
    wr(1'b0, 16'h8008); idle(3);
    wr(1'b0, 16'h8004); idle(3);
    wr(1'b0, 16'h0004); idle(2);
    curReq = "R6";
    wr(1'b0, 16'h000C); idle(4);
    wr(1'b0, 16'h0008);
    wr(1'b1, 16'h0001);
    wr(1'b0, 16'h000C); idle(1100);
    wr(1'b1, 16'h0002);
    wr(1'b0, 16'h0004);
    wr(1'b0, 16'h000C); idle(2100);
    curReq = "R5";
    wr(1'b1, 16'h0001);
    wr(1'b0, 16'h0008);
    wr(1'b0, 16'h000C); idle(10);
    wr(1'b0, 16'h8008); idle(10);
    wr(1'b0, 16'h8004); idle(1100);
    curReq = "R7";
    wr(1'b0, 16'h0008);
    wr(1'b0, 16'h000C); idle(5);
    wr(1'b1, 16'h0003); idle(1100);
    curReq = "R8";
    wr(1'b0, 16'h0004); idle(2);
    wr(1'b0, 16'h0008); idle(2);
    wr(1'b0, 16'h8000); idle(2);
    curReq = "R1";
    @(negedge clk); rstN = 1'b0; idle(3);
    rstN = 1'b1; idle(2);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule